// File: doc/BRIEF.md
# Low-Power Halt Sequencer

This block decides when a small controller's processor, peripherals and main oscillator may run, and brings them back in order after a halt. It watches a one-cycle halt strobe from the processor. The strobe's effect depends on two configuration inputs:

- With the auto-wake enable set, the block stops the main oscillator and hands timing to a separate low-frequency wake oscillator.
- Otherwise, with the active-halt select set, the main oscillator is kept running.
- Otherwise, all clocks stop (plain halt).

In every halt state the processor and peripheral enables are low.

Each halt flavour has its own set of interrupt lines that can end it, and reset can end any of them. When the main oscillator was stopped, it is restarted at once and a stabilization count of 256 or 4096 cycles must run out before the processor is enabled. Leaving active halt by an interrupt resumes on the next edge. Leaving it by reset still runs the count. The exit ends with a one-cycle request:

- a reset-vector fetch when the cause was reset;
- an interrupt service request otherwise, which also raises an interrupt-mask flag. The flag holds until the handler signals its return.

The processor, the stack push and the analog oscillators sit outside the block; they appear only as enables, strobes and the wake-timer tick.

Top module: `halt_sequencer`

## Requirements
- R1: A `halt_req` strobe in run state with `awake_en`=0 and `active_halt_en`=1 enters active halt on that edge: `osc_en`=1, `cpu_en`=0, `periph_en`=0.
- R2: A `halt_req` strobe with `awake_en`=0 and `active_halt_en`=0 enters plain halt: `osc_en`, `cpu_en`, `periph_en` and `wkosc_en` all 0.
- R3: A `halt_req` strobe with `awake_en`=1 enters auto-wake halt regardless of `active_halt_en`: `osc_en`=0, `cpu_en`=0, `wkosc_en`=1.
- R4: Wake sources depend on the flavour. With the default masks, active halt is woken only by `irq[0]` (the real-time-clock line) or `irq[1]`. Plain halt is woken only by `irq[1]` or `irq[3]`. Auto-wake halt is woken by `awake_tick`, `irq[1]` or `irq[3]`. Any other line leaves all outputs unchanged.
- R5: In active halt, a valid wake interrupt with no reset request makes `cpu_en`, `periph_en` and `service_irq` 1 on the edge that samples it, with `stab_done` staying 0.
- R6: Waking from plain or auto-wake halt sets `osc_en`=1 and `wkosc_en`=0 on the wake edge. `cpu_en` and `stab_done` then rise exactly L edges later, where L is 256 if `long_delay` was 0 and 4096 if it was 1 on the halt entry edge; later changes of `long_delay` have no effect. `stab_done` is high for one cycle.
- R7: A `sys_rst_req` in active halt keeps `osc_en`=1 and `cpu_en`=0, and runs the same L-edge stabilization before the processor is enabled.
- R8: Each exit from halt ends with exactly one of two one-cycle pulses, issued on the edge where `cpu_en` rises: `fetch_reset` for a reset cause, `service_irq` for an interrupt cause.
- R9: `irq_mask` becomes 1 together with `service_irq` and stays 1 until an `irq_return` strobe, or until a `fetch_reset` pulse clears it.
- R10: A reset request sampled together with a wake interrupt is taken as a reset exit. A reset request during a stabilization count turns that exit into a reset exit, without restarting the count.
- R11: A `sys_rst_req` in run state gives a `fetch_reset` pulse on the next edge, and a `halt_req` sampled with it is ignored.
- R12: After `rst`, `osc_en`, `periph_en` and `cpu_en` are 1; `wkosc_en`, `stab_done`, `fetch_reset`, `service_irq` and `irq_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high block reset |
| halt_req | input | 1 | One-cycle halt strobe from the processor |
| active_halt_en | input | 1 | Selects active halt when auto-wake is off |
| awake_en | input | 1 | Selects auto-wake halt |
| long_delay | input | 1 | Stabilization length select, 0: 256, 1: 4096 cycles |
| sys_rst_req | input | 1 | Chip reset request, an exit cause |
| irq | input | N_IRQ | Interrupt request lines, bit 0 is the real-time clock |
| awake_tick | input | 1 | Expiry of the external auto-wake timer |
| irq_return | input | 1 | Handler-return strobe, clears the mask flag |
| osc_en | output | 1 | Main oscillator enable |
| wkosc_en | output | 1 | Low-frequency wake oscillator enable |
| periph_en | output | 1 | Peripheral clock enable |
| cpu_en | output | 1 | Processor clock enable |
| stab_done | output | 1 | One-cycle pulse at the end of the stabilization count |
| fetch_reset | output | 1 | One-cycle reset-vector fetch request |
| service_irq | output | 1 | One-cycle interrupt service request |
| irq_mask | output | 1 | Interrupt-mask flag, set during the handler |

## Verification
Every output is a register, so every result appears on the first edge that samples its cause. A halt entry, an ignored interrupt, an active-halt interrupt exit, a run-state reset and a mask change are each checked one edge after the stimulus. A stabilization exit is checked twice:

- after L-1 edges, where `cpu_en` and `stab_done` must still be 0;
- after exactly L edges, where both must be 1 together with the exit pulse.

When a reset arrives partway through the count, the check edges are shifted by the edges already consumed. Inputs change and outputs are read at falling edges, so each check lands between the edge that produces the value and the next.

// File: rtl/lphs_pkg.sv
package lphs_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_ACT,
    ST_HLT,
    ST_AWK,
    ST_STAB
  } seq_state_t;
endpackage

// File: rtl/lphs_wake_filter.sv
module lphs_wake_filter
  import lphs_pkg::*;
#(
  parameter int unsigned N_IRQ = 4,
  parameter logic [N_IRQ-1:0] ACT_MASK = 4'b0011,
  parameter logic [N_IRQ-1:0] HLT_MASK = 4'b1010
) (
  input  seq_state_t       state,
  input  logic [N_IRQ-1:0] irq,
  input  logic             awake_tick,
  output logic             irq_ok
);
  logic act_hit;
  logic hlt_hit;

  assign act_hit = |(irq & ACT_MASK);
  assign hlt_hit = |(irq & HLT_MASK);

  always_comb begin
    unique case (state)
      ST_ACT:  irq_ok = act_hit;
      ST_HLT:  irq_ok = hlt_hit;
      ST_AWK:  irq_ok = hlt_hit | awake_tick;
      default: irq_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/lphs_stab_timer.sv
module lphs_stab_timer #(
  parameter int unsigned SHORT_CYC = 256,
  parameter int unsigned LONG_CYC  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  output logic expire
);
  localparam int unsigned CW = $clog2(LONG_CYC);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= long_sel ? LONG_LD : SHORT_LD;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expire = active && (cnt == '0);

  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0 && !start) |=> (cnt == $past(cnt) - 1'b1)); // R6
  AST_TMR_STOPS: assert property (@(posedge clk) disable iff (rst)
    (expire && !start) |=> !active); // R6
endmodule

// File: rtl/lphs_irq_mask.sv
module lphs_irq_mask (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic mask
);
  always_ff @(posedge clk) begin
    if (rst)      mask <= 1'b0;
    else if (set) mask <= 1'b1;
    else if (clr) mask <= 1'b0;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mask && !clr && !set) |=> mask); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    set |=> mask); // R9
endmodule

// File: rtl/halt_sequencer.sv
module halt_sequencer
  import lphs_pkg::*;
#(
  parameter int unsigned N_IRQ     = 4,
  parameter logic [N_IRQ-1:0] ACT_MASK = 4'b0011,
  parameter logic [N_IRQ-1:0] HLT_MASK = 4'b1010,
  parameter int unsigned SHORT_CYC = 256,
  parameter int unsigned LONG_CYC  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             active_halt_en,
  input  logic             awake_en,
  input  logic             long_delay,
  input  logic             sys_rst_req,
  input  logic [N_IRQ-1:0] irq,
  input  logic             awake_tick,
  input  logic             irq_return,
  output logic             osc_en,
  output logic             wkosc_en,
  output logic             periph_en,
  output logic             cpu_en,
  output logic             stab_done,
  output logic             fetch_reset,
  output logic             service_irq,
  output logic             irq_mask
);
  seq_state_t state, state_n;
  logic       cause_rst, cause_n;
  logic       long_q, long_n;
  logic       irq_ok, tmr_expire;
  logic       start_stab, go_reset, go_irq, done_n;

  lphs_wake_filter #(
    .N_IRQ(N_IRQ), .ACT_MASK(ACT_MASK), .HLT_MASK(HLT_MASK)
  ) u_filter (
    .state(state), .irq(irq), .awake_tick(awake_tick), .irq_ok(irq_ok)
  );

  lphs_stab_timer #(
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start_stab), .long_sel(long_q),
    .expire(tmr_expire)
  );

  lphs_irq_mask u_mask (
    .clk(clk), .rst(rst), .set(go_irq),
    .clr(irq_return | go_reset), .mask(irq_mask)
  );

  always_comb begin
    state_n    = state;
    cause_n    = cause_rst;
    long_n     = long_q;
    start_stab = 1'b0;
    go_reset   = 1'b0;
    go_irq     = 1'b0;
    done_n     = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (sys_rst_req) begin
          go_reset = 1'b1;
        end else if (halt_req) begin
          long_n = long_delay;
          if (awake_en)            state_n = ST_AWK;
          else if (active_halt_en) state_n = ST_ACT;
          else                     state_n = ST_HLT;
        end
      end
      ST_ACT: begin
        if (sys_rst_req) begin
          state_n    = ST_STAB;
          start_stab = 1'b1;
          cause_n    = 1'b1;
        end else if (irq_ok) begin
          state_n = ST_RUN;
          go_irq  = 1'b1;
        end
      end
      ST_HLT, ST_AWK: begin
        if (sys_rst_req || irq_ok) begin
          state_n    = ST_STAB;
          start_stab = 1'b1;
          cause_n    = sys_rst_req;
        end
      end
      ST_STAB: begin
        if (sys_rst_req) cause_n = 1'b1;
        if (tmr_expire) begin
          state_n = ST_RUN;
          done_n  = 1'b1;
          if (cause_n) go_reset = 1'b1;
          else         go_irq   = 1'b1;
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      cause_rst   <= 1'b0;
      long_q      <= 1'b0;
      osc_en      <= 1'b1;
      wkosc_en    <= 1'b0;
      periph_en   <= 1'b1;
      cpu_en      <= 1'b1;
      stab_done   <= 1'b0;
      fetch_reset <= 1'b0;
      service_irq <= 1'b0;
    end else begin
      state       <= state_n;
      cause_rst   <= cause_n;
      long_q      <= long_n;
      osc_en      <= !(state_n == ST_HLT || state_n == ST_AWK);
      wkosc_en    <= (state_n == ST_AWK);
      periph_en   <= (state_n == ST_RUN);
      cpu_en      <= (state_n == ST_RUN);
      stab_done   <= done_n;
      fetch_reset <= go_reset;
      service_irq <= go_irq;
    end
  end

  AST_HALT_CPU_OFF: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |-> (!cpu_en && !periph_en)); // R1
  AST_ACT_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT) |-> osc_en); // R1
  AST_PLAIN_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HLT) |-> (!osc_en && !wkosc_en)); // R2
  AST_AWK_OSC_SWAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AWK) |-> (wkosc_en && !osc_en)); // R3
  AST_STAB_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STAB) |-> (osc_en && !cpu_en)); // R6
  AST_CPU_RISE_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_en) |-> (stab_done || service_irq || fetch_reset)); // R6
  AST_DONE_WITH_CPU: assert property (@(posedge clk) disable iff (rst)
    stab_done |-> (cpu_en && (fetch_reset || service_irq))); // R8
  AST_EXIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fetch_reset && service_irq)); // R8
  AST_SERVICE_PULSE: assert property (@(posedge clk) disable iff (rst)
    service_irq |=> !service_irq); // R8
  AST_RESET_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STAB && sys_rst_req) |=> (cause_rst || fetch_reset)); // R10
endmodule

// File: tb/halt_sequencer_tb_top.sv
module halt_sequencer_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SHORT_L = 256;
  localparam int  LONG_L  = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_req = 1'b0, active_halt_en = 1'b0, awake_en = 1'b0;
  logic       long_delay = 1'b0, sys_rst_req = 1'b0, awake_tick = 1'b0;
  logic       irq_return = 1'b0;
  logic [3:0] irq = 4'b0000;
  logic osc_en, wkosc_en, periph_en, cpu_en, stab_done;
  logic fetch_reset, service_irq, irq_mask;

  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  halt_sequencer dut_i (
    .clk(clk), .rst(rst), .halt_req(halt_req), .active_halt_en(active_halt_en),
    .awake_en(awake_en), .long_delay(long_delay), .sys_rst_req(sys_rst_req),
    .irq(irq), .awake_tick(awake_tick), .irq_return(irq_return),
    .osc_en(osc_en), .wkosc_en(wkosc_en), .periph_en(periph_en),
    .cpu_en(cpu_en), .stab_done(stab_done), .fetch_reset(fetch_reset),
    .service_irq(service_irq), .irq_mask(irq_mask)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic enter_halt(input logic act_sel, input logic awk_sel, input logic lng);
    active_halt_en = act_sel;
    awake_en       = awk_sel;
    long_delay     = lng;
    halt_req       = 1'b1;
    step();
    halt_req       = 1'b0;
  endtask

  // n edges remain until cpu_en must rise; checks the edge before and the edge itself
  task automatic wait_stab(input int n, input string req);
    repeat (n - 1) step();
    check(req, "cpu_en one edge early", cpu_en, 1'b0);
    check(req, "stab_done one edge early", stab_done, 1'b0);
    step();
    check(req, "cpu_en at count end", cpu_en, 1'b1);
    check(req, "stab_done at count end", stab_done, 1'b1);
    check(req, "periph_en at count end", periph_en, 1'b1);
  endtask

  task automatic t_reset_state();
    check("R12", "osc_en", osc_en, 1'b1);
    check("R12", "periph_en", periph_en, 1'b1);
    check("R12", "cpu_en", cpu_en, 1'b1);
    check("R12", "wkosc_en", wkosc_en, 1'b0);
    check("R12", "stab_done", stab_done, 1'b0);
    check("R12", "fetch_reset", fetch_reset, 1'b0);
    check("R12", "service_irq", service_irq, 1'b0);
    check("R12", "irq_mask", irq_mask, 1'b0);
  endtask

  task automatic t_active_irq();
    enter_halt(1'b1, 1'b0, 1'b0);
    check("R1", "osc_en", osc_en, 1'b1);
    check("R1", "cpu_en", cpu_en, 1'b0);
    check("R1", "periph_en", periph_en, 1'b0);
    irq = 4'b0100; step();
    check("R4", "irq2 ignored in active halt", cpu_en, 1'b0);
    irq = 4'b1000; step();
    check("R4", "irq3 ignored in active halt", cpu_en, 1'b0);
    check("R4", "osc kept in active halt", osc_en, 1'b1);
    irq = 4'b0001; step(); irq = 4'b0000;
    check("R5", "cpu_en on wake edge", cpu_en, 1'b1);
    check("R5", "periph_en on wake edge", periph_en, 1'b1);
    check("R5", "service_irq", service_irq, 1'b1);
    check("R5", "no stab_done", stab_done, 1'b0);
    check("R9", "mask set", irq_mask, 1'b1);
    step();
    check("R8", "service_irq one cycle", service_irq, 1'b0);
    check("R9", "mask held", irq_mask, 1'b1);
    irq_return = 1'b1; step(); irq_return = 1'b0;
    check("R9", "mask cleared by return", irq_mask, 1'b0);
  endtask

  task automatic t_plain();
    enter_halt(1'b0, 1'b0, 1'b0);
    check("R2", "osc_en", osc_en, 1'b0);
    check("R2", "cpu_en", cpu_en, 1'b0);
    check("R2", "periph_en", periph_en, 1'b0);
    check("R2", "wkosc_en", wkosc_en, 1'b0);
    irq = 4'b0001; step(); irq = 4'b0000;
    check("R4", "irq0 ignored in plain halt", osc_en, 1'b0);
    irq = 4'b1000; step(); irq = 4'b0000;
    check("R6", "osc on at wake edge", osc_en, 1'b1);
    check("R6", "cpu off at wake edge", cpu_en, 1'b0);
    wait_stab(SHORT_L, "R6");
    check("R8", "service_irq after irq wake", service_irq, 1'b1);
    check("R8", "no fetch_reset after irq wake", fetch_reset, 1'b0);
    irq_return = 1'b1; step(); irq_return = 1'b0;
    check("R8", "stab_done one cycle", stab_done, 1'b0);
  endtask

  task automatic t_awake();
    enter_halt(1'b1, 1'b1, 1'b1);
    long_delay = 1'b0;
    check("R3", "osc_en", osc_en, 1'b0);
    check("R3", "wkosc_en", wkosc_en, 1'b1);
    check("R3", "cpu_en", cpu_en, 1'b0);
    irq = 4'b0001; step(); irq = 4'b0000;
    check("R4", "irq0 ignored in auto-wake halt", wkosc_en, 1'b1);
    awake_tick = 1'b1; step(); awake_tick = 1'b0;
    check("R6", "osc on after tick", osc_en, 1'b1);
    check("R6", "wake osc off after tick", wkosc_en, 1'b0);
    wait_stab(LONG_L, "R6");
    check("R8", "service_irq after tick", service_irq, 1'b1);
    irq_return = 1'b1; step(); irq_return = 1'b0;
    awake_en = 1'b0;
  endtask

  task automatic t_active_reset();
    enter_halt(1'b1, 1'b0, 1'b0);
    sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
    check("R7", "osc stays on", osc_en, 1'b1);
    check("R7", "cpu waits", cpu_en, 1'b0);
    wait_stab(SHORT_L, "R7");
    check("R8", "fetch_reset after reset exit", fetch_reset, 1'b1);
    check("R8", "no service_irq after reset exit", service_irq, 1'b0);
    step();
  endtask

  task automatic t_priority();
    enter_halt(1'b1, 1'b0, 1'b0);
    irq = 4'b0001; sys_rst_req = 1'b1; step();
    irq = 4'b0000; sys_rst_req = 1'b0;
    check("R10", "no immediate irq exit", cpu_en, 1'b0);
    check("R10", "no service_irq", service_irq, 1'b0);
    wait_stab(SHORT_L, "R10");
    check("R10", "fetch_reset wins", fetch_reset, 1'b1);
    step();
    enter_halt(1'b0, 1'b0, 1'b0);
    irq = 4'b0010; step(); irq = 4'b0000;
    sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
    wait_stab(SHORT_L - 1, "R10");
    check("R10", "reset during count gives fetch", fetch_reset, 1'b1);
    check("R10", "reset during count no service", service_irq, 1'b0);
    step();
  endtask

  task automatic t_run_reset();
    enter_halt(1'b1, 1'b0, 1'b0);
    irq = 4'b0010; step(); irq = 4'b0000;
    check("R9", "mask set before run reset", irq_mask, 1'b1);
    sys_rst_req = 1'b1; halt_req = 1'b1; step();
    sys_rst_req = 1'b0; halt_req = 1'b0;
    check("R11", "fetch_reset in run", fetch_reset, 1'b1);
    check("R11", "halt ignored cpu_en", cpu_en, 1'b1);
    check("R11", "halt ignored osc_en", osc_en, 1'b1);
    check("R9", "mask cleared by fetch_reset", irq_mask, 1'b0);
    step();
    check("R11", "fetch_reset one cycle", fetch_reset, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_active_irq();
    t_plain();
    t_awake();
    t_active_reset();
    t_priority();
    t_run_reset();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule